// File: doc/BRIEF.md
# Two-Mode Stopwatch and Countdown Counting Core

This block keeps the count for a timer that can act either as a hundredths-resolution stopwatch or as a two-minute countdown. Its state lives in two cascaded, loadable program-counter units. The low unit holds the fast field, which is hundredths in the stopwatch mode and seconds in the countdown mode. The high unit holds the slow field, which is seconds or minutes. Both fields always count upward. In the countdown mode, a later display stage turns the elapsed count into a remaining count. This block does not generate ticks and does not drive any display.

Every register runs on one system clock. A one-cycle `tick` enable sets the counting rate: 100 Hz for the stopwatch and 1 Hz for the countdown. The core never sees a mode-select signal. It behaves only according to a set of configuration inputs. These give the reset value of each field, the point where the low field wraps, and the pair of field values where counting freezes. A single pushbutton level starts and pauses the count on alternate presses.

Stopwatch configuration: wrap 100, reset 0/0, freeze at low 99, high 99.
Countdown configuration: wrap 60, reset 0/0, freeze at low 0, high 2. Two elapsed minutes reads as 00:00 after reversal.

Top module: `duoTimerCore`

## Requirements
- R1: While `rstN` is low, `lowCount` and `highCount` equal `cfgLowReset` and `cfgHighReset`. This takes effect at once, without waiting for a clock edge, and holds for as long as `rstN` stays low.
- R2: After reset is released the timer is stopped, and ticks leave both counts unchanged until the first button press.
- R3: Only the rising edge of `startStop` (0 to 1, after synchronisation) toggles the run state. Holding the button high, or releasing it, causes no further toggle.
- R4: While running, a cycle with `tick` low leaves both counts unchanged.
- R5: While running and below the freeze point, a tick with `lowCount` below `cfgLowWrap`-1 adds one to `lowCount` and leaves `highCount` unchanged.
- R6: While running and below the freeze point, a tick with `lowCount` equal to `cfgLowWrap`-1 loads `lowCount` with 0 and adds one to `highCount`. `highCount` changes on no other tick.
- R7: Once `lowCount` equals `cfgStopLow` and `highCount` equals `cfgStopHigh`, ticks are ignored and both counts hold until reset.
- R8: A second press pauses counting and holds both counts. A third press resumes counting from the held values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle count enable at the mode's rate |
| startStop | input | 1 | Start/stop pushbutton level, high when pressed |
| cfgLowWrap | input | CntW | Modulus of the low field (100 or 60) |
| cfgLowReset | input | CntW | Reset value of the low field |
| cfgHighReset | input | CntW | Reset value of the high field |
| cfgStopLow | input | CntW | Low-field value of the freeze point |
| cfgStopHigh | input | CntW | High-field value of the freeze point |
| lowCount | output | CntW | Low (fast) field, binary, counting up |
| highCount | output | CntW | High (slow) field, binary, counting up |

## Verification
The bench builds the core with its defaults: 8-bit fields and a two-stage button synchroniser. The two-stage synchroniser gives a fixed three-cycle latency from press to run toggle, which the button task covers. Because the tick is driven as a plain enable on the fast clock, the full stopwatch range fits inside a short run. That range is 9999 ticks, enough to reach the 99/99 freeze and to test that it holds. The bench also drives the countdown configuration through both 60-wraps to its 0/2 freeze, and a non-zero reset pair of 50/7, so that the reset values and the wrap modulus are shown to come from the inputs.

// File: rtl/duoTimerPkg.sv
package duoTimerPkg;

  // Strobes from the control unit to the datapath, one per counter action.
  typedef struct packed {
    logic incLow;
    logic loadLow;
    logic incHigh;
  } ctrlStrobes_t;

endpackage

// File: rtl/pcUnit.sv
module pcUnit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         resetHi,
  input  logic [W-1:0] resetVal,
  input  logic [W-1:0] loadVal,
  input  logic         load,
  input  logic         inc,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] One = W'(1);

  // Reset applies the reset value at once; load and increment wait for the clock.
  always_ff @(posedge clk or posedge resetHi) begin
    if (resetHi) begin
      count <= resetVal;
    end else if (load) begin
      count <= loadVal;
    end else if (inc) begin
      count <= count + One;
    end
  end

endmodule

// File: rtl/timerDatapath.sv
module timerDatapath
  import duoTimerPkg::*;
#(
  parameter int CntW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobes_t    strobes,
  input  logic [CntW-1:0] cfgLowWrap,
  input  logic [CntW-1:0] cfgLowReset,
  input  logic [CntW-1:0] cfgHighReset,
  input  logic [CntW-1:0] cfgStopLow,
  input  logic [CntW-1:0] cfgStopHigh,
  output logic [CntW-1:0] lowCount,
  output logic [CntW-1:0] highCount,
  output logic            lowAtWrap,
  output logic            atStop
);

  localparam logic [CntW-1:0] Zero = '0;
  localparam logic [CntW-1:0] One  = CntW'(1);

  logic resetHi;
  assign resetHi = ~rstN;

  pcUnit #(.W(CntW)) uLow (
    .clk      (clk),
    .resetHi  (resetHi),
    .resetVal (cfgLowReset),
    .loadVal  (Zero),
    .load     (strobes.loadLow),
    .inc      (strobes.incLow),
    .count    (lowCount)
  );

  pcUnit #(.W(CntW)) uHigh (
    .clk      (clk),
    .resetHi  (resetHi),
    .resetVal (cfgHighReset),
    .loadVal  (Zero),
    .load     (1'b0),
    .inc      (strobes.incHigh),
    .count    (highCount)
  );

  assign lowAtWrap = (lowCount == (cfgLowWrap - One));
  assign atStop    = (lowCount == cfgStopLow) && (highCount == cfgStopHigh);

endmodule

// File: rtl/timerControl.sv
module timerControl
  import duoTimerPkg::*;
#(
  parameter int SyncStages = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tick,
  input  logic         startStop,
  input  logic         lowAtWrap,
  input  logic         atStop,
  output ctrlStrobes_t strobes
);

  logic [SyncStages-1:0] syncReg;
  logic                  prevLevel;
  logic                  pressEdge;
  logic                  runFlag;
  logic                  advance;

  // Synchroniser chain for the button level.
  generate
    if (SyncStages == 1) begin : gSyncOne
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncReg <= '0;
        else       syncReg <= startStop;
      end
    end else begin : gSyncMany
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncReg <= '0;
        else       syncReg <= {syncReg[SyncStages-2:0], startStop};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLevel <= 1'b0;
    else       prevLevel <= syncReg[SyncStages-1];
  end

  assign pressEdge = syncReg[SyncStages-1] & ~prevLevel;

  // Run flag: cleared by reset, flipped on each press edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          runFlag <= 1'b0;
    else if (pressEdge) runFlag <= ~runFlag;
  end

  assign advance = tick & runFlag & ~atStop;

  always_comb begin
    strobes         = '0;
    strobes.incLow  = advance & ~lowAtWrap;
    strobes.loadLow = advance & lowAtWrap;
    strobes.incHigh = advance & lowAtWrap;
  end

endmodule

// File: rtl/duoTimerCore.sv
module duoTimerCore
  import duoTimerPkg::*;
#(
  parameter int CntW       = 8,
  parameter int SyncStages = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            tick,
  input  logic            startStop,
  input  logic [CntW-1:0] cfgLowWrap,
  input  logic [CntW-1:0] cfgLowReset,
  input  logic [CntW-1:0] cfgHighReset,
  input  logic [CntW-1:0] cfgStopLow,
  input  logic [CntW-1:0] cfgStopHigh,
  output logic [CntW-1:0] lowCount,
  output logic [CntW-1:0] highCount
);

  ctrlStrobes_t strobes;
  logic         lowAtWrap;
  logic         atStop;

  timerControl #(.SyncStages(SyncStages)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (tick),
    .startStop (startStop),
    .lowAtWrap (lowAtWrap),
    .atStop    (atStop),
    .strobes   (strobes)
  );

  timerDatapath #(.CntW(CntW)) uPath (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .cfgLowWrap   (cfgLowWrap),
    .cfgLowReset  (cfgLowReset),
    .cfgHighReset (cfgHighReset),
    .cfgStopLow   (cfgStopLow),
    .cfgStopHigh  (cfgStopHigh),
    .lowCount     (lowCount),
    .highCount    (highCount),
    .lowAtWrap    (lowAtWrap),
    .atStop       (atStop)
  );

endmodule

// File: rtl/duoTimerCoreChk.sv
module duoTimerCoreChk #(
  parameter int CntW = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            tick,
  input logic [CntW-1:0] cfgLowWrap,
  input logic [CntW-1:0] cfgLowReset,
  input logic [CntW-1:0] cfgHighReset,
  input logic [CntW-1:0] cfgStopLow,
  input logic [CntW-1:0] cfgStopHigh,
  input logic [CntW-1:0] lowCount,
  input logic [CntW-1:0] highCount
);

  localparam logic [CntW-1:0] One = CntW'(1);

  logic frozen;
  logic lastLow;
  assign frozen  = (lowCount == cfgStopLow) && (highCount == cfgStopHigh);
  assign lastLow = (lowCount == (cfgLowWrap - One));

  AST_RESET_VALUE: assert property (@(posedge clk)
    !rstN |-> (lowCount == cfgLowReset) && (highCount == cfgHighReset)); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(lowCount) && $stable(highCount)); // R4

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !lastLow && !frozen) |=>
      ((lowCount == $past(lowCount) + One) || $stable(lowCount)) && $stable(highCount)); // R5

  AST_WRAP_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (tick && lastLow && !frozen) |=>
      ((lowCount == '0) && (highCount == $past(highCount) + One)) ||
      ($stable(lowCount) && $stable(highCount))); // R6

  AST_HIGH_ONLY_ON_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    !lastLow |=> $stable(highCount)); // R6

  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    frozen |=> $stable(lowCount) && $stable(highCount)); // R7

endmodule

bind duoTimerCore duoTimerCoreChk #(.CntW(CntW)) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .tick         (tick),
  .cfgLowWrap   (cfgLowWrap),
  .cfgLowReset  (cfgLowReset),
  .cfgHighReset (cfgHighReset),
  .cfgStopLow   (cfgStopLow),
  .cfgStopHigh  (cfgStopHigh),
  .lowCount     (lowCount),
  .highCount    (highCount)
);

// File: tb/sim_duoTimerCore.sv
module sim_duoTimerCore;

  localparam int CntW = 8;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            tick = 1'b0;
  logic            startStop = 1'b0;
  logic [CntW-1:0] cfgLowWrap = 8'd100;
  logic [CntW-1:0] cfgLowReset = 8'd0;
  logic [CntW-1:0] cfgHighReset = 8'd0;
  logic [CntW-1:0] cfgStopLow = 8'd99;
  logic [CntW-1:0] cfgStopHigh = 8'd99;
  logic [CntW-1:0] lowCount;
  logic [CntW-1:0] highCount;

  always #4 clk = ~clk;

  duoTimerCore #(.CntW(CntW), .SyncStages(2)) u0 (
    .clk          (clk),
    .rstN         (rstN),
    .tick         (tick),
    .startStop    (startStop),
    .cfgLowWrap   (cfgLowWrap),
    .cfgLowReset  (cfgLowReset),
    .cfgHighReset (cfgHighReset),
    .cfgStopLow   (cfgStopLow),
    .cfgStopHigh  (cfgStopHigh),
    .lowCount     (lowCount),
    .highCount    (highCount)
  );

  typedef struct {
    int    expLow;
    int    expHigh;
    string req;
  } expItem_t;

  expItem_t expQ[$];
  event     chkEv;
  int       checks = 0;
  int       errors = 0;
  bit       done = 0;

  // Reference model, built from the requirements.
  int  mLow, mHigh;
  bit  mRun;

  task automatic expectNow(input string req);
    expItem_t it;
    it.expLow  = mLow;
    it.expHigh = mHigh;
    it.req     = req;
    expQ.push_back(it);
    ->chkEv;
    #0;
  endtask

  // Monitor: pops expected items and compares them with the outputs.
  initial begin
    forever begin
      @(chkEv);
      while (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        checks++;
        if (int'(lowCount) != it.expLow || int'(highCount) != it.expHigh) begin
          errors++;
          $display("FAIL %s: actual %0d/%0d expected %0d/%0d",
                   it.req, lowCount, highCount, it.expLow, it.expHigh);
        end
      end
    end
  end

  task automatic modelReset();
    mLow  = int'(cfgLowReset);
    mHigh = int'(cfgHighReset);
    mRun  = 0;
  endtask

  task automatic applyReset(input string req);
    @(negedge clk);
    #1 rstN = 1'b0;
    modelReset();
    #1 expectNow(req);
    repeat (3) @(negedge clk);
    expectNow(req);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic press(input int hold);
    @(negedge clk);
    startStop = 1'b1;
    repeat (hold) @(negedge clk);
    startStop = 1'b0;
    repeat (4) @(negedge clk);
    mRun = !mRun;
  endtask

  task automatic runTicks(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      if (mRun && !(mLow == int'(cfgStopLow) && mHigh == int'(cfgStopHigh))) begin
        if (mLow == int'(cfgLowWrap) - 1) begin
          mLow = 0;
          mHigh++;
        end else begin
          mLow++;
        end
      end
    end
    tick = 1'b0;
    expectNow(req);
  endtask

  task automatic idle(input int n, input string req);
    repeat (n) @(negedge clk);
    expectNow(req);
  endtask

  initial begin
    modelReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    expectNow("R1 reset state");
    rstN = 1'b1;
    @(negedge clk);

    // Stopwatch configuration.
    runTicks(5, "R2 stopped after reset");
    press(3);
    idle(6, "R4 running, no tick");
    runTicks(7, "R5 single steps");
    press(20);
    runTicks(10, "R8 paused holds, R3 long hold toggles once");
    press(2);
    runTicks(93, "R6 wrap at 100 carries into high");
    runTicks(9899, "R6 reaches 99/99");
    runTicks(50, "R7 freeze at 99/99");
    applyReset("R1 async reset mid-run");
    runTicks(4, "R2 stopped after second reset");

    // Non-zero reset values.
    rstN = 1'b0;
    cfgLowReset  = 8'd50;
    cfgHighReset = 8'd7;
    applyReset("R1 configured reset 50/7");
    press(2);
    runTicks(49, "R5 count to 99/7");
    runTicks(1, "R6 wrap to 0/8");

    // Countdown configuration.
    rstN = 1'b0;
    cfgLowWrap   = 8'd60;
    cfgLowReset  = 8'd0;
    cfgHighReset = 8'd0;
    cfgStopLow   = 8'd0;
    cfgStopHigh  = 8'd2;
    applyReset("R1 countdown reset");
    press(2);
    runTicks(59, "R5 seconds to 59");
    runTicks(1, "R6 wrap at 60");
    runTicks(60, "R6 second wrap reaches 0/2");
    runTicks(5, "R7 countdown freeze");
    press(2);
    press(2);
    runTicks(3, "R7 freeze holds after resume");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule